// File: doc/BRIEF.md
# One-Position Bidirectional Shifter

This block is a combinational shifter for a data word of parameterized width (eight bits by default). It either passes the word through unchanged or moves it by exactly one bit position. The move can go toward the most significant end or toward the least significant end. The bit position left empty at the far end is filled with zero. There are no registers, so the output follows the inputs in the same cycle.

The word is processed by a row of identical one-bit selector slices. Each slice picks one of three sources: its own input bit, the input bit just below it, or the input bit just above it. One control decoder drives the selection, and every slice shares it. The two end slices are not special. Each gets a constant zero on the neighbour input that lies outside the word, and that zero produces the fill.

Two controls set the operation. `shift_en` chooses between pass-through and shift. `toward_msb` sets the direction and matters only while `shift_en` is high. Bit 0 is the least significant bit.

Top module: `shift_array`

## Requirements
- R1: With `shift_en`=0, `dout` equals `din` for either value of `toward_msb`.
- R2: With `shift_en`=1 and `toward_msb`=1, `dout[i]` equals `din[i-1]` for i=1..W-1. This is a logical left shift by one.
- R3: With `shift_en`=1 and `toward_msb`=1, `dout[0]` is 0.
- R4: With `shift_en`=1 and `toward_msb`=0, `dout[i]` equals `din[i+1]` for i=0..W-2. This is a logical right shift by one.
- R5: With `shift_en`=1 and `toward_msb`=0, `dout[W-1]` is 0.
- R6: A bit that is shifted out has no effect on the output. `din[W-1]` cannot change `dout` while shifting toward the MSB, and `din[0]` cannot change `dout` while shifting toward the LSB.
- R7: The path is purely combinational. `dout` reflects new inputs without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | W | Data word to pass through or shift |
| shift_en | input | 1 | 1 = shift by one position, 0 = pass through |
| toward_msb | input | 1 | Direction while shifting: 1 = toward bit W-1, 0 = toward bit 0 |
| dout | output | W | Resulting word |

## Verification
Every one of the 256 data values is applied under each of the four control combinations. Checking the pass-through modes over all values separates a correct pass-through from a path that ignores or mishandles `toward_msb`. The two shift modes are compared against an arithmetic doubling modulo 256 and a halving with the remainder dropped. Those comparisons catch a reversed direction, a wrong neighbour connection, or a fill bit that is not zero. Separate checks flip only the bit that is shifted out and confirm the output does not change, which exposes an end slice wired to the word instead of to constant zero.

// File: rtl/shift_pkg.sv
package shift_pkg;

  // Source picked by each one-bit slice.
  typedef enum logic [1:0] {
    PICK_OWN   = 2'd0,
    PICK_BELOW = 2'd1,
    PICK_ABOVE = 2'd2
  } pick_t;

  localparam int MAX_W = 64;

  // Control decode shared by every slice.
  function automatic pick_t pick_of(input logic en, input logic up);
    if (!en)      return PICK_OWN;
    else if (up)  return PICK_BELOW;
    else          return PICK_ABOVE;
  endfunction

  // Whole-word reference expressed with shift operators, masked to width w.
  function automatic logic [MAX_W-1:0] ref_shift(input logic [MAX_W-1:0] v,
                                                 input logic en,
                                                 input logic up,
                                                 input int w);
    logic [MAX_W-1:0] mask;
    logic [MAX_W-1:0] r;
    mask = (w >= MAX_W) ? '1 : ((64'd1 << w) - 64'd1);
    v    = v & mask;
    if (!en)     r = v;
    else if (up) r = v << 1;
    else         r = v >> 1;
    return r & mask;
  endfunction

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
(
  input  logic  shift_en,
  input  logic  toward_msb,
  output pick_t pick
);

  assign pick = pick_of(shift_en, toward_msb);

  always_comb begin
    if (!$isunknown({shift_en, toward_msb})) begin
      a_r1_hold_own: assert (shift_en || pick == PICK_OWN)
        else $error("R1: pick not OWN while idle");
      a_r2_dir_msb: assert (!(shift_en && toward_msb) || pick == PICK_BELOW)
        else $error("R2: pick not BELOW while moving up");
      a_r4_dir_lsb: assert (!(shift_en && !toward_msb) || pick == PICK_ABOVE)
        else $error("R4: pick not ABOVE while moving down");
    end
  end

endmodule

// File: rtl/shift_slice.sv
module shift_slice
  import shift_pkg::*;
(
  input  logic  own_bit,
  input  logic  below_bit,
  input  logic  above_bit,
  input  pick_t pick,
  output logic  out_bit
);

  always_comb begin
    unique case (pick)
      PICK_BELOW: out_bit = below_bit;
      PICK_ABOVE: out_bit = above_bit;
      default:    out_bit = own_bit;
    endcase
  end

endmodule

// File: rtl/shift_array.sv
module shift_array
  import shift_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  logic         shift_en,
  input  logic         toward_msb,
  output logic [W-1:0] dout
);

  localparam int TOP = W - 1;

  pick_t        pick;
  // Neighbour buses with the out-of-word ends tied to zero (the fill source).
  logic [W-1:0] below_bus;
  logic [W-1:0] above_bus;
  logic         fill_low;
  logic         fill_high;

  shift_ctrl u_ctrl (
    .shift_en   (shift_en),
    .toward_msb (toward_msb),
    .pick       (pick)
  );

  assign below_bus = {din[TOP-1:0], 1'b0};
  assign above_bus = {1'b0, din[TOP:1]};

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      shift_slice u_slice (
        .own_bit   (din[i]),
        .below_bit (below_bus[i]),
        .above_bit (above_bus[i]),
        .pick      (pick),
        .out_bit   (dout[i])
      );
    end
  endgenerate

  // Named boundary events for the checks.
  assign fill_low  = shift_en &  toward_msb;
  assign fill_high = shift_en & ~toward_msb;

  always_comb begin
    if (!$isunknown({din, shift_en, toward_msb, dout})) begin
      a_r3_low_zero: assert (!fill_low || dout[0] == 1'b0)
        else $error("R3: bit 0 not zero-filled");
      a_r5_high_zero: assert (!fill_high || dout[TOP] == 1'b0)
        else $error("R5: top bit not zero-filled");
      a_r7_match_ref: assert (MAX_W'(dout) ==
                              ref_shift(MAX_W'(din), shift_en, toward_msb, W))
        else $error("R7: output disagrees with reference");
    end
  end

endmodule

// File: tb/shift_array_test.sv
module shift_array_test;

  localparam int W = 8;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic [W-1:0] din = '0;
  logic         shift_en = 1'b0;
  logic         toward_msb = 1'b0;
  logic [W-1:0] dout;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  shift_array #(.W(W)) uut (
    .din        (din),
    .shift_en   (shift_en),
    .toward_msb (toward_msb),
    .dout       (dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] got,
                       input logic [W-1:0] exp, input int v, input int s, input int u);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s din=%0d s=%0d u=%0d actual=%0d expected=%0d",
               req, v, s, u, got, exp);
    end
  endtask

  task automatic apply(input int v, input int s, input int u);
    @(negedge clk);
    din = W'(v); shift_en = s[0]; toward_msb = u[0];
    #(CLK_PERIOD/4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // Idle state: all-zero inputs give all-zero output.
    apply(0, 0, 0);
    check("R1", dout, '0, 0, 0, 0);

    // R7: output updates within a quarter period, no clock edge in between.
    @(posedge clk);
    #1 din = 8'hA5; shift_en = 1'b1; toward_msb = 1'b1;
    #1 check("R7", dout, 8'h4A, 165, 1, 1);

    for (int s = 0; s < 2; s++) begin
      for (int u = 0; u < 2; u++) begin
        for (int v = 0; v < 256; v++) begin
          apply(v, s, u);
          if (s == 0) begin
            check("R1", dout, W'(v), v, s, u);
          end else if (u == 1) begin
            check("R2", dout, W'((v * 2) % 256), v, s, u);
            check("R3", {7'd0, dout[0]}, 8'd0, v, s, u);
          end else begin
            check("R4", dout, W'(v / 2), v, s, u);
            check("R5", {7'd0, dout[W-1]}, 8'd0, v, s, u);
          end
        end
      end
    end

    // R6: flipping the shifted-out bit leaves the output unchanged.
    for (int v = 0; v < 256; v += 17) begin
      logic [W-1:0] first;
      apply(v, 1, 1);
      first = dout;
      apply(v ^ 128, 1, 1);
      check("R6", dout, first, v, 1, 1);
      apply(v, 1, 0);
      first = dout;
      apply(v ^ 1, 1, 0);
      check("R6", dout, first, v, 1, 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule